// File: doc/BRIEF.md
# DRAM Self-Refresh Entry/Exit Sequencer

This block moves a DDR2-style memory into self refresh and brings it back out. The rest of the memory controller talks to it through two request inputs. A pulse on `enter_req` while the block is idle makes it issue one REFRESH command with CKE driven low. CKE is then held low and the command pins are parked at DESELECT. After a settling margin, the block reports that the memory clock may be stopped.

A later `exit_req` starts the way out. The block waits until the clock generator reports a run of consecutive stable-clock cycles, and only then raises CKE. It then keeps the command bus at NOP for a fixed post-exit window. That window is long enough both for any internal refresh to finish and for the DLL to relock. While the block is driving the bus, `ready` stays low. When `ready` rises, normal traffic may resume.

The internal state register is one-hot. It has six states: idle, entry, in self refresh, waiting for the clock, CKE raised, and post-exit. An exit request that arrives before the entry margin has elapsed is remembered. It is acted on as soon as the margin is satisfied.

Top module: `selfrefresh_seq`

## Requirements
- R1: After reset the block is idle. `ready`=1, `cke`=1, the command is DESELECT ({cs_n,ras_n,cas_n,we_n}=1111), and `sr_ack`=0 and `clk_stop_ok`=0.
- R2: When `enter_req` is sampled high while idle, the next cycle drives REFRESH (0001) with `cke`=0 and `ready`=0. This lasts exactly one cycle.
- R3: From the cycle after the REFRESH until the exit sequence raises CKE, `cke` stays 0 and the command is DESELECT. `sr_ack` is 1 exactly in the self-refresh holding state.
- R4: `clk_stop_ok` rises only once the holding state has lasted ENTRY_MARGIN cycles. It falls as soon as the block leaves that state.
- R5: Once an exit begins, `cke` stays 0 until `clk_stable` has been sampled high for CLK_LEAD consecutive cycles. A low sample restarts the count. CKE rises one cycle after the run completes.
- R6: An `exit_req` pulse seen during the REFRESH cycle, or before the margin of R4 has elapsed, is held. The exit then starts in the first cycle after the margin is met.
- R7: After CKE rises, the command is NOP (0111) with `ready`=0 for exactly POST_CYCLES cycles. After that the block returns to idle with `ready`=1 and DESELECT. POST_CYCLES is at least TXSNR_CYCLES and at least 2.
- R8: `enter_req` has no effect outside the idle state, and `exit_req` has no effect while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously outside the block |
| enter_req | input | 1 | Request to put the memory into self refresh |
| exit_req | input | 1 | Request to bring the memory out of self refresh |
| clk_stable | input | 1 | Memory clock meets its period spec this cycle |
| sr_ack | output | 1 | Memory is held in self refresh |
| clk_stop_ok | output | 1 | Memory clock may be stopped |
| ready | output | 1 | Sequencer idle; normal commands allowed |
| cke | output | 1 | Clock enable to the memory |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |

## Verification
The assertions assume that `clk_stable` tells the truth. The CKE rise is judged against the stable-clock history seen at the block's own input. The stimulus therefore drives `clk_stable` only as a pattern, including a single-cycle drop in the middle of a run, and never models a real clock stopping. Requests are driven as clean synchronous levels or one-cycle pulses, as the rest of the controller would drive them. Some are deliberately placed in states where they must be ignored. The bench sweeps the exit request across every offset from the REFRESH cycle up to past the margin, and predicts every output in every cycle by arithmetic.

// File: rtl/srseq_pkg.sv
package srseq_pkg;
  localparam int unsigned NUM_ST     = 6;
  localparam int unsigned ST_IDLE    = 0;
  localparam int unsigned ST_ENTER   = 1;
  localparam int unsigned ST_HOLD    = 2;
  localparam int unsigned ST_WAITCLK = 3;
  localparam int unsigned ST_CKEUP   = 4;
  localparam int unsigned ST_POST    = 5;

  typedef logic [NUM_ST-1:0] srseq_state_t;
  localparam srseq_state_t STATE_RESET = srseq_state_t'(1) << ST_IDLE;

  // Command bus as {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] ddr_cmd_t;
  localparam ddr_cmd_t CMD_DESEL = 4'b1111;
  localparam ddr_cmd_t CMD_NOP   = 4'b0111;
  localparam ddr_cmd_t CMD_REF   = 4'b0001;
endpackage

// File: rtl/srseq_counter.sv
module srseq_counter #(
  parameter int unsigned LIMIT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int unsigned W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign done = (cnt_q == W'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en && !done) begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/srseq_fsm.sv
module srseq_fsm
  import srseq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enter_req,
  input  logic         exit_go,
  input  logic         margin_done,
  input  logic         lead_done,
  input  logic         post_done,
  output srseq_state_t state_q
);
  srseq_state_t state_d;

  always_comb begin
    state_d = '0;
    case (1'b1)
      state_q[ST_IDLE]: begin
        if (enter_req) state_d[ST_ENTER] = 1'b1;
        else           state_d[ST_IDLE]  = 1'b1;
      end
      state_q[ST_ENTER]: state_d[ST_HOLD] = 1'b1;
      state_q[ST_HOLD]: begin
        if (exit_go && margin_done) state_d[ST_WAITCLK] = 1'b1;
        else                        state_d[ST_HOLD]    = 1'b1;
      end
      state_q[ST_WAITCLK]: begin
        if (lead_done) state_d[ST_CKEUP]   = 1'b1;
        else           state_d[ST_WAITCLK] = 1'b1;
      end
      state_q[ST_CKEUP]: state_d[ST_POST] = 1'b1;
      state_q[ST_POST]: begin
        if (post_done) state_d[ST_IDLE] = 1'b1;
        else           state_d[ST_POST] = 1'b1;
      end
      default: state_d[ST_IDLE] = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= STATE_RESET;
    end else begin
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/srseq_outdec.sv
module srseq_outdec
  import srseq_pkg::*;
(
  input  srseq_state_t state,
  output logic         cke,
  output ddr_cmd_t     cmd,
  output logic         sr_ack,
  output logic         ready
);
  always_comb begin
    cke    = ~(state[ST_ENTER] | state[ST_HOLD] | state[ST_WAITCLK]);
    sr_ack = state[ST_HOLD];
    ready  = state[ST_IDLE];
    if (state[ST_ENTER]) begin
      cmd = CMD_REF;
    end else if (state[ST_CKEUP] | state[ST_POST]) begin
      cmd = CMD_NOP;
    end else begin
      cmd = CMD_DESEL;
    end
  end
endmodule

// File: rtl/selfrefresh_seq.sv
module selfrefresh_seq
  import srseq_pkg::*;
#(
  parameter int unsigned ENTRY_MARGIN = 1,
  parameter int unsigned CLK_LEAD     = 1,
  parameter int unsigned TXSNR_CYCLES = 64,
  parameter int unsigned POST_CYCLES  = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_req,
  input  logic exit_req,
  input  logic clk_stable,
  output logic sr_ack,
  output logic clk_stop_ok,
  output logic ready,
  output logic cke,
  output logic cmd_cs_n,
  output logic cmd_ras_n,
  output logic cmd_cas_n,
  output logic cmd_we_n
);
  localparam int unsigned POST_LIMIT = POST_CYCLES - 1;

  srseq_state_t state_q;
  ddr_cmd_t     cmd_vec;
  logic         exit_pend_q;
  logic         exit_pend_d;
  logic         exit_go;
  logic         margin_done;
  logic         lead_done;
  logic         post_done;
  logic         in_entry;

  assign in_entry = state_q[ST_ENTER] | state_q[ST_HOLD];
  assign exit_go  = exit_req | exit_pend_q;

  always_comb begin
    exit_pend_d = 1'b0;
    if (in_entry) begin
      exit_pend_d = exit_pend_q | exit_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exit_pend_q <= 1'b0;
    end else begin
      exit_pend_q <= exit_pend_d;
    end
  end

  srseq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter_req  (enter_req),
    .exit_go    (exit_go),
    .margin_done(margin_done),
    .lead_done  (lead_done),
    .post_done  (post_done),
    .state_q    (state_q)
  );

  srseq_counter #(.LIMIT(ENTRY_MARGIN)) u_margin_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (~state_q[ST_HOLD]),
    .en   (state_q[ST_HOLD]),
    .done (margin_done)
  );

  srseq_counter #(.LIMIT(CLK_LEAD)) u_lead_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (~state_q[ST_WAITCLK] | ~clk_stable),
    .en   (clk_stable),
    .done (lead_done)
  );

  srseq_counter #(.LIMIT(POST_LIMIT)) u_post_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (~(state_q[ST_CKEUP] | state_q[ST_POST])),
    .en   (1'b1),
    .done (post_done)
  );

  srseq_outdec u_dec (
    .state (state_q),
    .cke   (cke),
    .cmd   (cmd_vec),
    .sr_ack(sr_ack),
    .ready (ready)
  );

  assign clk_stop_ok = state_q[ST_HOLD] & margin_done;
  assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd_vec;
endmodule

module selfrefresh_seq_chk
  import srseq_pkg::*;
#(
  parameter int unsigned CLK_LEAD     = 1,
  parameter int unsigned TXSNR_CYCLES = 64,
  parameter int unsigned POST_CYCLES  = 200
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clk_stable,
  input logic         cke,
  input logic         ready,
  input logic         sr_ack,
  input logic         clk_stop_ok,
  input ddr_cmd_t     cmd,
  input srseq_state_t state
);
  localparam int unsigned HMAX = (POST_CYCLES > TXSNR_CYCLES) ? POST_CYCLES : TXSNR_CYCLES;
  localparam int unsigned HW   = $clog2(HMAX + 1);
  localparam int unsigned SW   = $clog2(CLK_LEAD + 1);

  logic [HW-1:0] hi_cnt;
  logic [SW-1:0] stab_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (!cke || ready) begin
      hi_cnt <= '0;
    end else if (hi_cnt != HW'(HMAX)) begin
      hi_cnt <= hi_cnt + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stab_run <= '0;
    end else if (!clk_stable) begin
      stab_run <= '0;
    end else if (stab_run != SW'(CLK_LEAD)) begin
      stab_run <= stab_run + SW'(1);
    end
  end

  p_refresh_cke_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF) |-> !cke);

  p_refresh_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF) |-> $past(ready));

  p_onehot_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state) == 1);

  p_stop_only_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop_ok |-> (!cke && sr_ack && cmd == CMD_DESEL));

  p_cke_after_stable_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> ($past(stab_run) == SW'(CLK_LEAD)));

  p_window_nop_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !ready) |-> (cmd == CMD_NOP));

  p_window_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (hi_cnt == HW'(POST_CYCLES)));

  p_window_covers_txsnr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (hi_cnt >= HW'(TXSNR_CYCLES)));

  p_no_refresh_when_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> (cmd != CMD_REF));
endmodule

bind selfrefresh_seq selfrefresh_seq_chk #(
  .CLK_LEAD    (CLK_LEAD),
  .TXSNR_CYCLES(TXSNR_CYCLES),
  .POST_CYCLES (POST_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_stable (clk_stable),
  .cke        (cke),
  .ready      (ready),
  .sr_ack     (sr_ack),
  .clk_stop_ok(clk_stop_ok),
  .cmd        (cmd_vec),
  .state      (state_q)
);

// File: tb/selfrefresh_seq_bench.sv
module selfrefresh_seq_bench;
  localparam int M    = 2;
  localparam int P    = 3;
  localparam int POST = 8;
  localparam int TX   = 4;

  logic clk;
  logic rst_n;
  logic enter_req;
  logic exit_req;
  logic clk_stable;
  logic sr_ack;
  logic clk_stop_ok;
  logic ready;
  logic cke;
  logic cs_n, ras_n, cas_n, we_n;

  int n_tests;
  int n_fail;

  selfrefresh_seq #(
    .ENTRY_MARGIN(M),
    .CLK_LEAD    (P),
    .TXSNR_CYCLES(TX),
    .POST_CYCLES (POST)
  ) u_selfrefresh_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter_req  (enter_req),
    .exit_req   (exit_req),
    .clk_stable (clk_stable),
    .sr_ack     (sr_ack),
    .clk_stop_ok(clk_stop_ok),
    .ready      (ready),
    .cke        (cke),
    .cmd_cs_n   (cs_n),
    .cmd_ras_n  (ras_n),
    .cmd_cas_n  (cas_n),
    .cmd_we_n   (we_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Observed vector: {cke, cmd[3:0], ready, sr_ack, clk_stop_ok}
  function automatic logic [7:0] expect_vec(input logic k, input logic [3:0] c,
                                            input logic r, input logic a, input logic o);
    return {k, c, r, a, o};
  endfunction

  task automatic check(input string tag, input int cyc, input logic [7:0] exp_v);
    logic [7:0] act_v;
    act_v = {cke, cs_n, ras_n, cas_n, we_n, ready, sr_ack, clk_stop_ok};
    n_tests++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act_v, exp_v);
    end
  endtask

  localparam logic [7:0] V_IDLE = {1'b1, 4'b1111, 1'b1, 1'b0, 1'b0};

  // d: exit pulse offset after the REFRESH cycle; g: clock glitch position (0 = none)
  task automatic run_seq(input int d, input int g, input bit noise);
    int L, S, X, E;
    string tw;
    L = (d + 1 > M + 2) ? d + 1 : M + 2;
    S = (g > 0) ? g + 1 : 0;
    X = L + P + 2 + S;
    E = X + POST;
    if (g > 0) tw = "R5";
    else if (d + 1 < M + 2) tw = "R6";
    else tw = "R5";
    for (int n = 0; n <= E; n++) begin
      if (n == 0) begin
        check(noise ? "R8" : "R1", n, V_IDLE);
      end else if (n == 1) begin
        check(noise ? "R8" : "R2", n, expect_vec(1'b0, 4'b0001, 1'b0, 1'b0, 1'b0));
      end else if (n <= L) begin
        check(noise ? "R8" : ((n - 2 >= M) ? "R4" : "R3"), n,
              expect_vec(1'b0, 4'b1111, 1'b0, 1'b1, (n - 2 >= M)));
      end else if (n < X) begin
        check(noise ? "R8" : tw, n, expect_vec(1'b0, 4'b1111, 1'b0, 1'b0, 1'b0));
      end else if (n < E) begin
        check(noise ? "R8" : "R7", n, expect_vec(1'b1, 4'b0111, 1'b0, 1'b0, 1'b0));
      end else begin
        check(noise ? "R8" : "R7", n, V_IDLE);
      end
      enter_req = (n == 0) || (noise && n >= 2 && n <= E - 1);
      exit_req  = (n == d + 1) || (noise && n > L && n < E);
      if (g == 0) clk_stable = 1'b1;
      else clk_stable = ((n >= L + 1) && (n <= L + g)) || (n >= L + g + 2);
      if (n == E) begin
        enter_req = 1'b0;
        exit_req  = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    enter_req  = 1'b0;
    exit_req   = 1'b0;
    clk_stable = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 0, V_IDLE);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 0, V_IDLE);

    // R5 R6: exit offsets from the REFRESH cycle to past the margin
    for (int d = 0; d <= M + 3; d++) begin
      run_seq(d, 0, 1'b0);
    end
    // R5: a single low sample restarts the stable-clock run
    for (int g = 1; g < P; g++) begin
      run_seq(M, g, 1'b0);
    end
    // R8: requests held high in states where they must be ignored
    run_seq(0, 0, 1'b1);
    run_seq(M + 2, 1, 1'b1);

    // R8: exit request while idle leaves the block idle
    clk_stable = 1'b1;
    for (int i = 0; i < 5; i++) begin
      exit_req = 1'b1;
      @(negedge clk);
      check("R8", i, V_IDLE);
    end
    exit_req = 1'b0;
    @(negedge clk);
    check("R8", 5, V_IDLE);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule